// File: doc/BRIEF.md
# Grouped Power Rail Sequencer

This block brings a board's power rails up in a fixed order of groups. Each group has its own set of enable outputs and a subset of those rails report a power-good level back. A group is considered complete once every monitored rail of that group reads good. A group that also contains unmonitored rails must, in addition, wait a programmable settle time. Only then are the rails of the next group switched on. Once the fifth rail group is complete, the block enters its final stage: it raises the module power-good output and releases both the system reset and the manual reset lines.

The master enable, the fault input and every power-good input arrive asynchronously and pass through two-flop synchronizers. Power-good inputs are active high, because open-drain outputs with pull-ups read high when good. Three events make the block shut down and return to idle: a monitored rail failing to report good within a timeout, a good rail dropping, or a regulator fault. Shutdown removes the groups one at a time, highest group first, and latches a fault code that names the cause. Dropping the master enable performs the same orderly shutdown without recording a code. The interface is plain control and status; there is no streamed data.

Top module: `pwrseq_top`

## Requirements
- R1: During and right after reset, all 22 rail enables are low, the module power-good is low, both reset outputs are low (asserted), and status_o is zero.
- R2: While the synchronized master enable is low, the block stays idle with every rail enable low.
- R3: Groups turn on one at a time in order 1..5. All rails of a group rise in the same cycle. A group turns on only after every monitored power-good of all lower groups reads high. Enable bit ranges: group 1 = [2:0], group 2 = [9:3], group 3 = [15:10], group 4 = [20:16], group 5 = [21]. Power-good bit ranges: group 1 = [2:0], group 2 = [6:3], group 3 = [12:7], group 4 = [13], group 5 = [14]. Within each group, monitored rails occupy the lowest enable bits, in the same order as their power-good bits.
- R4: Groups 2 and 4 contain unmonitored rails and stay on for at least SETTLE_CYC cycles before the next group starts. Group 1, which is fully monitored, advances as soon as its power-good inputs read good.
- R5: After group 5 reports good, mod_pg_o, sys_rst_n_o and man_rst_n_o go high together, and man_rst_n_o is never high while mod_pg_o is low.
- R6: If the monitored power-good of the group being brought up is still missing TIMEOUT_CYC cycles after that group was enabled, the block shuts down and latches fault code = that group's number (1..5).
- R7: Dropping the master enable at any stage shuts the block down to idle and latches no fault code (code 0).
- R8: If a power-good of an already completed group falls low, the block shuts down and latches fault code 6.
- R9: A low level on the active-low regulator fault input during bring-up or while on shuts the block down and latches fault code 7.
- R10: A latched non-zero fault code holds, and blocks a restart, until the master enable is seen low. The code then clears to 0, and the next rising enable starts a fresh bring-up.
- R11: Shutdown removes one group at a time, highest first, spaced SETTLE_CYC cycles apart. At every cycle, any rail of group g being enabled implies every rail of all lower groups is enabled. mod_pg_o and both reset outputs fall when shutdown begins.
- R12: status_o[20:18] is the fault code. status_o[17:15] is the current stage: 0 when idle, 1..5 for the highest group enabled, 6 when fully on. status_o[14:0] holds the synchronized power-good inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_en_i | input | 1 | Master enable, asynchronous |
| fault_n_i | input | 1 | Regulator fault, active low, asynchronous |
| pg_i | input | 15 | Monitored power-good levels, high = good |
| rail_en_o | output | 22 | Rail enables, grouped as listed in R3 |
| mod_pg_o | output | 1 | Module power-good, high in the final stage |
| sys_rst_n_o | output | 1 | System reset, released (high) in the final stage |
| man_rst_n_o | output | 1 | Manual reset, released (high) in the final stage |
| status_o | output | 21 | Fault code, stage and synchronized power-good bits (R12) |

## Verification
On every cycle, the assertions check several invariants. The stage counter moves by at most one per cycle. It only steps up after the current group's power-good is complete, and it never rises during shutdown. Idle always means no groups are on. A latched code stays put while the enable is held. The timeout counter saturates. The manual reset is never released ahead of the module power-good. The enables stay nested by group. What only the bench scenarios can show are the end-to-end effects: the settle spacing measured between groups, the timeout duration, which fault code each failure cause produces, the re-arm after the enable is dropped, and the final released state.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam int NGRP = 5;
  // rails per group, and how many of them report power-good (monitored first)
  localparam int RCNT [NGRP] = '{3, 7, 6, 5, 1};
  localparam int PCNT [NGRP] = '{3, 4, 6, 1, 1};

  localparam logic [2:0] CODE_NONE  = 3'd0;
  localparam logic [2:0] CODE_LOST  = 3'd6;
  localparam logic [2:0] CODE_FAULT = 3'd7;
  localparam logic [2:0] STAGE_ON   = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_UP, S_ON, S_DOWN} seq_st_e;

  function automatic int rail_base(int g);
    int s = 0;
    for (int k = 1; k <= NGRP; k++) if (k < g) s += RCNT[k-1];
    return s;
  endfunction

  function automatic int pg_base(int g);
    int s = 0;
    for (int k = 1; k <= NGRP; k++) if (k < g) s += PCNT[k-1];
    return s;
  endfunction

  localparam int NRAIL = rail_base(NGRP + 1);
  localparam int NPG   = pg_base(NGRP + 1);
  localparam int STW   = 6 + NPG;

  function automatic logic [NRAIL-1:0] rail_upto(int lvl);
    logic [NRAIL-1:0] m = '0;
    for (int i = 0; i < NRAIL; i++) m[i] = (i < rail_base(lvl + 1));
    return m;
  endfunction

  function automatic logic [NPG-1:0] pg_upto(int lvl);
    logic [NPG-1:0] m = '0;
    for (int i = 0; i < NPG; i++) m[i] = (i < pg_base(lvl + 1));
    return m;
  endfunction

  function automatic logic [NPG-1:0] pg_of(int g);
    return pg_upto(g) & ~pg_upto(g - 1);
  endfunction

  function automatic logic needs_settle(int g);
    logic r = 1'b0;
    for (int k = 1; k <= NGRP; k++) if (k == g) r = (RCNT[k-1] != PCNT[k-1]);
    return r;
  endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= RST_VAL[i];
        stab <= RST_VAL[i];
      end else begin
        meta <= d_i[i];
        stab <= meta;
      end
    end
    assign q_o[i] = stab;
  end
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int SETTLE_CYC  = 100000,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic settle_done,
  output logic timeout
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] T_MAX = CW'(TIMEOUT_CYC);
  localparam logic [CW-1:0] S_MAX = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (cnt != T_MAX) cnt <= cnt + 1'b1;
  end

  assign settle_done = (cnt >= S_MAX);
  assign timeout     = (cnt == T_MAX);

  p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n) cnt <= T_MAX);
  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (cnt == '0));
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_s,
  input  logic           fault_n_s,
  input  logic [NPG-1:0] pg_s,
  input  logic           settle_done,
  input  logic           timeout,
  output logic           tmr_clr,
  output logic [2:0]     lvl_o,
  output logic           on_o,
  output logic [2:0]     code_o
);
  seq_st_e state, state_n;
  logic [2:0] lvl, lvl_n, code, code_n;
  logic [NPG-1:0] held;
  logic grp_ok, lost, settle_ok;

  always_comb begin
    grp_ok    = &(pg_s | ~pg_of(int'(lvl)));
    held      = (state == S_ON) ? pg_upto(NGRP) : pg_upto(int'(lvl) - 1);
    lost      = |(held & ~pg_s);
    settle_ok = !needs_settle(int'(lvl)) || settle_done;
    state_n   = state;
    lvl_n     = lvl;
    code_n    = code;
    tmr_clr   = 1'b0;
    case (state)
      S_IDLE: begin
        if (!en_s) code_n = CODE_NONE;
        else if (code == CODE_NONE) begin
          state_n = S_UP;
          lvl_n   = 3'd1;
          tmr_clr = 1'b1;
        end
      end
      S_UP, S_ON: begin
        if (!fault_n_s || lost || !en_s || (state == S_UP && timeout && !grp_ok)) begin
          state_n = S_DOWN;
          tmr_clr = 1'b1;
          if (code == CODE_NONE) begin
            if (!fault_n_s)  code_n = CODE_FAULT;
            else if (lost)   code_n = CODE_LOST;
            else if (en_s)   code_n = lvl;
          end
        end else if (state == S_UP && grp_ok && settle_ok) begin
          tmr_clr = 1'b1;
          if (lvl == 3'(NGRP)) state_n = S_ON;
          else                 lvl_n   = lvl + 3'd1;
        end
      end
      S_DOWN: begin
        if (settle_done) begin
          tmr_clr = 1'b1;
          lvl_n   = lvl - 3'd1;
          if (lvl == 3'd1) state_n = S_IDLE;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      lvl   <= 3'd0;
      code  <= CODE_NONE;
    end else begin
      state <= state_n;
      lvl   <= lvl_n;
      code  <= code_n;
    end
  end

  assign lvl_o  = lvl;
  assign on_o   = (state == S_ON);
  assign code_o = code;

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != $past(lvl)) |-> ((lvl == $past(lvl) + 3'd1) || (lvl == $past(lvl) - 3'd1)));
  p_upok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl > $past(lvl)) && ($past(state) == S_UP)) |-> $past(grp_ok));
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (lvl == 3'd0));
  p_down_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DOWN) |=> (lvl <= $past(lvl)));
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((code != CODE_NONE) && en_s) |=> (code == $past(code)));
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int SETTLE_CYC  = 100000,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en_i,
  input  logic             fault_n_i,
  input  logic [NPG-1:0]   pg_i,
  output logic [NRAIL-1:0] rail_en_o,
  output logic             mod_pg_o,
  output logic             sys_rst_n_o,
  output logic             man_rst_n_o,
  output logic [STW-1:0]   status_o
);
  localparam int SW = NPG + 2;

  logic [SW-1:0]  sync_q;
  logic           en_s, fault_n_s, settle_done, timeout, tmr_clr, on;
  logic [NPG-1:0] pg_s;
  logic [2:0]     lvl, code;

  pwrseq_sync #(.W(SW), .RST_VAL({1'b1, 1'b0, {NPG{1'b0}}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({fault_n_i, mod_en_i, pg_i}), .q_o(sync_q));
  assign {fault_n_s, en_s, pg_s} = sync_q;

  pwrseq_timer #(.SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr),
    .settle_done(settle_done), .timeout(timeout));

  pwrseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .fault_n_s(fault_n_s), .pg_s(pg_s),
    .settle_done(settle_done), .timeout(timeout), .tmr_clr(tmr_clr),
    .lvl_o(lvl), .on_o(on), .code_o(code));

  // registered outputs: no decode glitches reach the regulators
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rail_en_o   <= '0;
      mod_pg_o    <= 1'b0;
      sys_rst_n_o <= 1'b0;
      man_rst_n_o <= 1'b0;
      status_o    <= '0;
    end else begin
      rail_en_o   <= rail_upto(int'(lvl));
      mod_pg_o    <= on;
      sys_rst_n_o <= on;
      man_rst_n_o <= on;
      status_o    <= {code, (on ? STAGE_ON : lvl), pg_s};
    end
  end

  p_man_after_pg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    man_rst_n_o |-> mod_pg_o);

  for (genvar g = 2; g <= NGRP; g++) begin : g_nest
    localparam int LO = rail_base(g - 1);
    localparam int HI = rail_base(g) - 1;
    p_nest_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rail_en_o[rail_base(g)] |-> (&rail_en_o[HI:LO]));
  end
endmodule

// File: tb/pwrseq_top_tb.sv
module pwrseq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE  = 20;
  localparam int TMO     = 200;
  localparam int NR = 22;
  localparam int NP = 15;
  localparam int BR [5] = '{0, 3, 10, 16, 21};
  localparam int RC [5] = '{3, 7, 6, 5, 1};
  localparam int BP [5] = '{0, 3, 7, 13, 14};
  localparam int PC [5] = '{3, 4, 6, 1, 1};

  logic clk = 0, rst_n = 0, en = 0, fault_n = 1;
  logic [NP-1:0] stuck = '0;
  logic [NP-1:0] pg;
  logic [NR-1:0] rail_en;
  logic mod_pg, sys_rst_n, man_rst_n;
  logic [20:0] status;
  int checks = 0, failures = 0, cyc = 0, nest_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwrseq_top #(.SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .mod_en_i(en), .fault_n_i(fault_n), .pg_i(pg),
    .rail_en_o(rail_en), .mod_pg_o(mod_pg), .sys_rst_n_o(sys_rst_n),
    .man_rst_n_o(man_rst_n), .status_o(status));

  function automatic int pg2rail(int k);
    int r = 0;
    for (int g = 0; g < 5; g++)
      if (k >= BP[g] && k < BP[g] + PC[g]) r = BR[g] + k - BP[g];
    return r;
  endfunction

  // regulator model: power-good follows its enable unless held stuck low
  always_comb
    for (int k = 0; k < NP; k++) pg[k] = rail_en[pg2rail(k)] & ~stuck[k];

  function automatic logic grp_all(int g);
    logic a = 1'b1;
    for (int i = 0; i < RC[g]; i++) a &= rail_en[BR[g] + i];
    return a;
  endfunction

  function automatic logic grp_any(int g);
    logic a = 1'b0;
    for (int i = 0; i < RC[g]; i++) a |= rail_en[BR[g] + i];
    return a;
  endfunction

  // nesting monitor (R11)
  always @(negedge clk)
    if (rst_n)
      for (int g = 1; g < 5; g++)
        if (grp_any(g) && !grp_all(g - 1)) nest_err++;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    tick(3);
    chk(rail_en == 0 && !mod_pg && !sys_rst_n && !man_rst_n, "R1 outputs in reset",
        {rail_en, mod_pg, sys_rst_n, man_rst_n}, 0);
    rst_n = 1;
    tick(2);
    chk(status == 0 && rail_en == 0, "R1 status after reset", status, 0);
  endtask

  task automatic t_idle;
    tick(100);
    chk(rail_en == 0 && !mod_pg, "R2 idle with enable low", rail_en, 0);
  endtask

  task automatic t_powerup;
    int t_on [5];
    int t_pg = -1;
    for (int g = 0; g < 5; g++) t_on[g] = -1;
    en = 1;
    for (int n = 0; n < 3000 && t_pg < 0; n++) begin
      @(negedge clk);
      for (int g = 0; g < 5; g++)
        if (t_on[g] < 0 && rail_en[BR[g]]) begin
          t_on[g] = cyc;
          chk(grp_all(g), "R3 group rails rise together", g, 1);
          for (int h = 0; h < g; h++)
            for (int i = 0; i < PC[h]; i++)
              if (!pg[BP[h] + i]) chk(1'b0, "R3 lower power-good before group", g, h);
        end
      if (mod_pg) begin
        t_pg = cyc;
        chk(sys_rst_n && man_rst_n, "R5 resets released with power-good",
            {sys_rst_n, man_rst_n}, 3);
      end else if (man_rst_n) chk(1'b0, "R5 manual reset early", man_rst_n, 0);
    end
    chk(t_on[0] < t_on[1] && t_on[1] < t_on[2] && t_on[2] < t_on[3] &&
        t_on[3] < t_on[4] && t_on[4] < t_pg && t_on[0] >= 0, "R3 group order", t_pg, 1);
    chk(t_on[2] - t_on[1] >= SETTLE, "R4 group 2 settle", t_on[2] - t_on[1], SETTLE);
    chk(t_on[4] - t_on[3] >= SETTLE, "R4 group 4 settle", t_on[4] - t_on[3], SETTLE);
    chk(t_on[1] - t_on[0] < SETTLE, "R4 monitored group needs no settle",
        t_on[1] - t_on[0], SETTLE);
    chk(status == {3'd0, 3'd6, 15'h7fff}, "R12 status when on", status, {3'd0, 3'd6, 15'h7fff});
  endtask

  task automatic wait_down(input logic [2:0] code, input string req);
    int t0 = cyc;
    int top = 0;
    for (int g = 0; g < 5; g++) if (grp_any(g)) top = g + 1;
    nest_err = 0;
    tick(4);
    chk(!mod_pg && !man_rst_n && !sys_rst_n, "R11 outputs drop at shutdown",
        {mod_pg, man_rst_n, sys_rst_n}, 0);
    for (int n = 0; n < 3000 && rail_en != 0; n++) @(negedge clk);
    chk(rail_en == 0, "R11 all rails off", rail_en, 0);
    chk(cyc - t0 >= top * SETTLE, "R11 groups spaced by settle", cyc - t0, top * SETTLE);
    chk(nest_err == 0, "R11 reverse order nesting", nest_err, 0);
    tick(2);
    chk(status[20:18] == code && status[17:15] == 0, req, status[20:15], {code, 3'd0});
  endtask

  task automatic t_endrop;
    t_powerup();
    en = 0;
    wait_down(3'd0, "R7 enable drop code 0");
  endtask

  task automatic t_loss_rearm;
    t_powerup();
    stuck[7] = 1;
    wait_down(3'd6, "R8 power-good loss code 6");
    tick(100);
    chk(rail_en == 0 && status[20:18] == 3'd6, "R10 no restart while code latched",
        {rail_en, status[20:18]}, 6);
    stuck = '0;
    en = 0;
    tick(10);
    chk(status[20:18] == 3'd0, "R10 code cleared by enable low", status[20:18], 0);
    t_powerup();
    chk(mod_pg, "R10 restart after re-arm", mod_pg, 1);
    en = 0;
    wait_down(3'd0, "R7 shutdown after re-arm");
  endtask

  task automatic t_timeout;
    int ton = -1;
    int dur = 0;
    stuck[13] = 1;
    en = 1;
    for (int n = 0; n < 3000 && ton < 0; n++) begin
      @(negedge clk);
      if (rail_en[16]) ton = cyc;
    end
    for (int n = 0; n < 3000 && rail_en[16]; n++) @(negedge clk);
    dur = cyc - ton;
    chk(ton >= 0 && dur >= TMO, "R6 timeout duration", dur, TMO);
    chk(!rail_en[21], "R6 group 5 never enabled", rail_en[21], 0);
    wait_down(3'd4, "R6 timeout code names group 4");
    stuck = '0;
    en = 0;
    tick(10);
  endtask

  task automatic t_fault;
    t_powerup();
    fault_n = 0;
    wait_down(3'd7, "R9 fault input code 7");
    fault_n = 1;
    en = 0;
    tick(10);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_endrop();
    t_loss_rearm();
    t_timeout();
    t_fault();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule